// File: doc/BRIEF.md
# Byte Shift/Rotate Unit with Branch Condition Test

This block is the shift and rotate slice of a small processor datapath. Each cycle it can accept one byte operand, an incoming carry and a 3-bit operation select. It produces the shifted or rotated byte, the carry that leaves the byte, and three status flags derived from the result: sign, zero, and a logic-zero flag that is set when the upper half of the result is all zeros. The result and its flags are registered and appear one cycle after the request. They stay unchanged while no request is presented.

Beside the datapath sits a condition evaluator. It is used for conditional jumps and returns. It takes a 3-bit condition code and the current flag vector and drives a condition-true bit straight through combinational logic, with no register on the path. The code selects one of the four flags, and the low bit of the code chooses whether that flag must be set or clear. The same flag bit that holds logic-zero after a shift holds overflow after an arithmetic operation, so two conditions serve both meanings.

The flag vector uses the same packing on the input and the output. Bit 3 is sign (S), bit 2 is zero (Z), bit 1 is logic-zero/overflow (LV) and bit 0 is carry (C).

Top module: `srk_unit`

## Requirements
- R1: Operation select 000 (rotate left through carry) gives result = {operand[6:0], carry_in} and carry out = operand[7].
- R2: Operation select 001 (circular rotate left) gives result = {operand[6:0], operand[7]} and carry out = operand[7].
- R3: Operation select 010 (rotate right through carry) gives result = {carry_in, operand[7:1]}. Operation select 011 (circular rotate right) gives result = {operand[0], operand[7:1]}. In both cases carry out = operand[0].
- R4: Operation select 100 (arithmetic left shift) gives result = {operand[6:0], 0} and carry out = operand[7].
- R5: Operation select 101 (arithmetic right shift) gives result = {operand[7], operand[7:1]}. Operation select 110 (logical right shift) gives result = {0, operand[7:1]}. In both cases carry out = operand[0].
- R6: Operation select 111 passes the operand through unchanged. Carry out equals carry_in.
- R7: flags_out packs S in bit 3, Z in bit 2, LV in bit 1 and C in bit 0. S = result[7], Z = 1 exactly when the result is zero, LV = 1 exactly when result[7:4] is zero, and C is the carry out.
- R8: cond_true is combinational from cond_code and flags_in and changes in the same cycle as its inputs. The mapping is: 000 is Z clear, 001 is Z set, 010 is C clear, 011 is C set, 100 is LV clear, 101 is LV set, 110 is S clear, 111 is S set.
- R9: Results are valid one clock after a request. res_valid is high in the cycle after op_valid is high and low otherwise. result and flags_out hold their value while op_valid is low.
- R10: While reset is asserted, and until the first request after reset is released, res_valid, result and flags_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| op_valid | input | 1 | Request strobe; the inputs below are captured when it is high |
| op_sel | input | 3 | Shift/rotate operation select |
| operand | input | 8 | Byte to shift or rotate |
| carry_in | input | 1 | Incoming carry |
| cond_code | input | 3 | Condition code to test |
| flags_in | input | 4 | Current flag vector {S, Z, LV, C} |
| res_valid | output | 1 | Result register holds a new result |
| result | output | 8 | Registered shift/rotate result |
| flags_out | output | 4 | Registered flags {S, Z, LV, C} of the result |
| cond_true | output | 1 | Condition code satisfied by flags_in |

## Verification
The assertions take for granted that requests arrive only after the internal synchronized reset is released. They also take for granted that cond_code and flags_in stay steady around each clock edge, because the condition properties sample them at the edge. The bench drives every input on the falling edge and waits several cycles after releasing reset before it issues the first request. The operation stream sweeps all eight selects with operands that cover zero, all ones, alternating bits and single set bits at each end, under both carry values. The condition evaluator is driven through every code paired with every flag combination.

// File: rtl/srk_pkg.sv
package srk_pkg;

  localparam int FLAG_W = 4;
  localparam int S_IDX  = 3;
  localparam int Z_IDX  = 2;
  localparam int LV_IDX = 1;
  localparam int C_IDX  = 0;

  typedef enum logic [2:0] {
    OP_RL_CARRY  = 3'b000,
    OP_RL_CIRC   = 3'b001,
    OP_RR_CARRY  = 3'b010,
    OP_RR_CIRC   = 3'b011,
    OP_SHL_ARITH = 3'b100,
    OP_SHR_ARITH = 3'b101,
    OP_SHR_LOGIC = 3'b110,
    OP_PASS      = 3'b111
  } shift_op_e;

  // Flag tested by each pair of condition codes: Z, C, LV, S.
  function automatic int cond_flag_idx(input int pair);
    case (pair)
      0:       return Z_IDX;
      1:       return C_IDX;
      2:       return LV_IDX;
      default: return S_IDX;
    endcase
  endfunction

endpackage

// File: rtl/srk_shifter.sv
module srk_shifter
  import srk_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_op_e      op,
  input  logic [W-1:0]   a,
  input  logic           cin,
  output logic [W-1:0]   y,
  output logic           cout
);

  localparam int MSB = W - 1;

  always_comb begin
    y    = a;
    cout = cin;
    case (op)
      OP_RL_CARRY: begin  // R1
        y    = {a[MSB-1:0], cin};
        cout = a[MSB];
      end
      OP_RL_CIRC: begin   // R2
        y    = {a[MSB-1:0], a[MSB]};
        cout = a[MSB];
      end
      OP_RR_CARRY: begin  // R3
        y    = {cin, a[MSB:1]};
        cout = a[0];
      end
      OP_RR_CIRC: begin   // R3
        y    = {a[0], a[MSB:1]};
        cout = a[0];
      end
      OP_SHL_ARITH: begin // R4
        y    = {a[MSB-1:0], 1'b0};
        cout = a[MSB];
      end
      OP_SHR_ARITH: begin // R5
        y    = {a[MSB], a[MSB:1]};
        cout = a[0];
      end
      OP_SHR_LOGIC: begin // R5
        y    = {1'b0, a[MSB:1]};
        cout = a[0];
      end
      default: begin      // R6 pass-through
        y    = a;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/srk_flaggen.sv
module srk_flaggen
  import srk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      y,
  input  logic              cout,
  output logic [FLAG_W-1:0] flags
);

  localparam int HALF = W / 2;

  always_comb begin
    flags         = '0;
    flags[S_IDX]  = y[W-1];
    flags[Z_IDX]  = ~|y;
    flags[LV_IDX] = ~|y[W-1 -: HALF];
    flags[C_IDX]  = cout;
  end

endmodule

// File: rtl/srk_cond_eval.sv
module srk_cond_eval
  import srk_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);

  localparam int NCODES = 1 << CODE_W;

  logic [NCODES-1:0] test_vec;

  for (genvar g = 0; g < NCODES; g++) begin : g_test
    localparam int FIDX   = cond_flag_idx(g / 2);
    localparam bit WANT_1 = (g % 2) == 1;
    if (WANT_1) begin : g_set
      assign test_vec[g] = flags[FIDX];
    end else begin : g_clr
      assign test_vec[g] = ~flags[FIDX];
    end
  end

  assign hit = test_vec[code];

endmodule

// File: rtl/srk_unit.sv
module srk_unit
  import srk_pkg::*;
#(
  parameter int W      = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic [W-1:0]      operand,
  input  logic              carry_in,
  input  logic [2:0]        cond_code,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              res_valid,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags_out,
  output logic              cond_true
);

  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_N-1];

  // Datapath.
  logic [W-1:0]      sh_y;
  logic              sh_cout;
  logic [FLAG_W-1:0] sh_flags;

  srk_shifter #(.W(W)) u_shifter (
    .op   (shift_op_e'(op_sel)),
    .a    (operand),
    .cin  (carry_in),
    .y    (sh_y),
    .cout (sh_cout)
  );

  srk_flaggen #(.W(W)) u_flaggen (
    .y     (sh_y),
    .cout  (sh_cout),
    .flags (sh_flags)
  );

  srk_cond_eval #(.CODE_W(3)) u_cond (
    .code  (cond_code),
    .flags (flags_in),
    .hit   (cond_true)
  );

  // Result register: next-state logic.
  logic              valid_q, valid_d;
  logic [W-1:0]      res_q, res_d;
  logic [FLAG_W-1:0] flg_q, flg_d;

  always_comb begin
    valid_d = op_valid;
    res_d   = res_q;
    flg_d   = flg_q;
    if (op_valid) begin
      res_d = sh_y;
      flg_d = sh_flags;
    end
  end

  // Result register: state.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
      flg_q   <= flg_d;
    end
  end

  assign res_valid = valid_q;
  assign result    = res_q;
  assign flags_out = flg_q;

endmodule

// File: rtl/srk_unit_chk.sv
module srk_unit_chk
  import srk_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              op_valid,
  input logic [2:0]        op_sel,
  input logic [W-1:0]      operand,
  input logic              carry_in,
  input logic [2:0]        cond_code,
  input logic [FLAG_W-1:0] flags_in,
  input logic              res_valid,
  input logic [W-1:0]      result,
  input logic [FLAG_W-1:0] flags_out,
  input logic              cond_true
);

  localparam int HALF = W / 2;

  AST_RL_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_sel == 3'b000) |=> (result[0] == $past(carry_in) && flags_out[C_IDX] == $past(operand[W-1]))); // R1

  AST_RL_CIRC_WRAP: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_sel == 3'b001) |=> (result[0] == $past(operand[W-1]) && flags_out[C_IDX] == $past(operand[W-1]))); // R2

  AST_RR_CIRC_WRAP: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_sel == 3'b011) |=> (result[W-1] == $past(operand[0]) && flags_out[C_IDX] == $past(operand[0]))); // R3

  AST_SHL_FILL: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_sel == 3'b100) |=> (result[0] == 1'b0 && flags_out[C_IDX] == $past(operand[W-1]))); // R4

  AST_SHR_ARITH_SIGN: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_sel == 3'b101) |=> (result[W-1] == $past(operand[W-1]) && flags_out[C_IDX] == $past(operand[0]))); // R5

  AST_SHR_LOGIC_FILL: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_sel == 3'b110) |=> (result[W-1] == 1'b0 && flags_out[C_IDX] == $past(operand[0]))); // R5

  AST_PASS_KEEP: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_sel == 3'b111) |=> (result == $past(operand) && flags_out[C_IDX] == $past(carry_in))); // R6

  AST_FLAG_SIGN: assert property (@(posedge clk) disable iff (!rst_ok)
    res_valid |-> flags_out[S_IDX] == result[W-1]); // R7

  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    res_valid |-> flags_out[Z_IDX] == (result == '0)); // R7

  AST_FLAG_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    res_valid |-> flags_out[LV_IDX] == (result[W-1 -: HALF] == '0)); // R7

  AST_COND_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_ok)
    (cond_code[2:1] == 2'b00) |-> cond_true == (flags_in[Z_IDX] == cond_code[0])); // R8

  AST_COND_SIGN_TEST: assert property (@(posedge clk) disable iff (!rst_ok)
    (cond_code[2:1] == 2'b11) |-> cond_true == (flags_in[S_IDX] == cond_code[0])); // R8

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_ok)
    op_valid |=> res_valid); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> (!res_valid && $stable(result) && $stable(flags_out))); // R9

endmodule

bind srk_unit srk_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .operand   (operand),
  .carry_in  (carry_in),
  .cond_code (cond_code),
  .flags_in  (flags_in),
  .res_valid (res_valid),
  .result    (result),
  .flags_out (flags_out),
  .cond_true (cond_true)
);

// File: tb/tb_srk_unit.sv
`timescale 1ns/1ps
module tb_srk_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_sel;
  logic [7:0] operand;
  logic       carry_in;
  logic [2:0] cond_code;
  logic [3:0] flags_in;
  logic       res_valid;
  logic [7:0] result;
  logic [3:0] flags_out;
  logic       cond_true;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] q_res[$];
  logic [3:0] q_flg[$];
  int         q_req[$];
  logic [7:0] last_res;
  logic [3:0] last_flg;

  always #5 clk = ~clk;

  srk_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .carry_in(carry_in), .cond_code(cond_code),
    .flags_in(flags_in), .res_valid(res_valid), .result(result),
    .flags_out(flags_out), .cond_true(cond_true)
  );

  // Reference model from the requirements.
  task automatic model(input logic [2:0] op, input logic [7:0] a, input logic c,
                       output logic [7:0] y, output logic [3:0] f, output int req);
    logic co;
    case (op)
      3'd0: begin y = {a[6:0], c};    co = a[7]; req = 1; end // R1
      3'd1: begin y = {a[6:0], a[7]}; co = a[7]; req = 2; end // R2
      3'd2: begin y = {c, a[7:1]};    co = a[0]; req = 3; end // R3
      3'd3: begin y = {a[0], a[7:1]}; co = a[0]; req = 3; end // R3
      3'd4: begin y = {a[6:0], 1'b0}; co = a[7]; req = 4; end // R4
      3'd5: begin y = {a[7], a[7:1]}; co = a[0]; req = 5; end // R5
      3'd6: begin y = {1'b0, a[7:1]}; co = a[0]; req = 5; end // R5
      default: begin y = a;           co = c;    req = 6; end // R6
    endcase
    f = {y[7], (y == 8'h00), (y[7:4] == 4'h0), co}; // R7
  endtask

  // Driver: presents one request and pushes its expectation.
  task automatic drive_op(input logic [2:0] op, input logic [7:0] a, input logic c);
    logic [7:0] y;
    logic [3:0] f;
    int req;
    @(negedge clk);
    op_valid = 1'b1;
    op_sel   = op;
    operand  = a;
    carry_in = c;
    model(op, a, c, y, f, req);
    q_res.push_back(y);
    q_flg.push_back(f);
    q_req.push_back(req);
    last_res = y;
    last_flg = f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
      operand  = ~operand;
      carry_in = ~carry_in;
      op_sel   = op_sel + 3'd1;
    end
  endtask

  // Monitor: pops expectations as results appear.
  always @(negedge clk) begin
    if (rst_n && res_valid && !done) begin
      if (q_res.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R9: unexpected result %h, expected no result", result);
      end else begin
        logic [7:0] er;
        logic [3:0] ef;
        int rq;
        er = q_res.pop_front();
        ef = q_flg.pop_front();
        rq = q_req.pop_front();
        n_tests++;
        if (result !== er) begin
          n_fail++;
          $display("FAIL R%0d: result %h, expected %h", rq, result, er);
        end
        n_tests++;
        if (flags_out !== ef) begin
          n_fail++;
          $display("FAIL R7: flags %b, expected %b", flags_out, ef);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual %h, expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic cond_ref(input logic [2:0] code, input logic [3:0] f);
    case (code) // R8 mapping
      3'd0: return !f[2];
      3'd1: return  f[2];
      3'd2: return !f[0];
      3'd3: return  f[0];
      3'd4: return !f[1];
      3'd5: return  f[1];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  initial begin
    logic [7:0] pats [10];
    pats = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h80, 8'h01, 8'h0F, 8'hF0, 8'h10, 8'h08};
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 3'd0; operand = 8'h00;
    carry_in = 1'b0; cond_code = 3'd0; flags_in = 4'h0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(res_valid == 1'b0, "R10", "res_valid", 32'(res_valid), 0);
    check(result == 8'h00,   "R10", "result",    32'(result),    0);
    check(flags_out == 4'h0, "R10", "flags_out", 32'(flags_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_valid == 1'b0 && result == 8'h00, "R10", "post-release result", 32'(result), 0);

    // R1..R7: sweep all selects, patterns and carries, back to back
    for (int op = 0; op < 8; op++)
      for (int p = 0; p < 10; p++)
        for (int c = 0; c < 2; c++)
          drive_op(3'(op), pats[p], 1'(c));
    idle(3);

    // R9: hold while idle
    check(res_valid == 1'b0, "R9", "res_valid idle", 32'(res_valid), 0);
    check(result == last_res, "R9", "held result", 32'(result), 32'(last_res));
    check(flags_out == last_flg, "R9", "held flags", 32'(flags_out), 32'(last_flg));

    // R9: single request, one cycle latency
    drive_op(3'd5, 8'h96, 1'b1);
    @(negedge clk);
    op_valid = 1'b0;
    check(res_valid == 1'b1, "R9", "valid one cycle later", 32'(res_valid), 1);
    idle(2);
    check(q_res.size() == 0, "R9", "pending expectations", 32'(q_res.size()), 0);

    // R8: every code against every flag vector, same cycle
    for (int cc = 0; cc < 8; cc++)
      for (int fv = 0; fv < 16; fv++) begin
        @(negedge clk);
        cond_code = 3'(cc);
        flags_in  = 4'(fv);
        #1;
        check(cond_true == cond_ref(3'(cc), 4'(fv)), "R8", "cond_true",
              32'(cond_true), 32'(cond_ref(3'(cc), 4'(fv))));
      end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule